// File: doc/BRIEF.md
# Dual-Channel Keyboard/Mouse Host Controller

This block is a byte-wide host-side controller for two serial input devices: a keyboard channel and an auxiliary (mouse) channel. The host sees two byte addresses, selected by one select input. One carries data. The other takes commands on a write and returns status on a read. Internally the block keeps a status byte, a configuration byte and one output byte buffer. The host reads that buffer through the data address.

Some commands take effect at once. Others arm a pending action, and the next data-address write completes it. That write can be forwarded to the keyboard, forwarded to the mouse, stored as the configuration, looped back into the output buffer as if one channel had sent it, or taken as an output-port value. Whenever the output buffer is empty, it refills from the device receive streams, with the keyboard taking priority. Each load of the buffer can raise a one-cycle interrupt pulse for the channel that the byte is attributed to. The device side uses plain valid/ready byte streams.

Top module: `ps2_host_ctrl`

## Requirements
- R1: After reset the status byte reads 0x1C (bit2 system flag, bit3 last-write-was-command, bit4 keyboard unlocked) and the configuration byte is 0x45 (bit0 keyboard interrupt enable, bit2 system flag, bit6 translation); the error output is 0 and no interrupt is raised.
- R2: A read with the command select high returns the status byte combinationally and changes no state; status bit0 is output-full, bit1 is always 0, bit5 is mouse-output-full.
- R3: Any command-address write sets status bit3 on the next cycle; any data-address write clears it.
- R4: A data write with no pending action presents the byte on the keyboard transmit stream; valid and data hold until the cycle in which ready is high.
- R5: After command 0xD4 the next data write goes to the mouse transmit stream; any data write returns the pending action to none, so the following data write goes to the keyboard.
- R6: After command 0x60 the next data write replaces the configuration byte, and status bit2 takes that byte's bit2.
- R7: After command 0xD2 (keyboard) or 0xD3 (mouse) the next data write loads the output buffer: status bit0 becomes 1, and status bit5 becomes 1 only for 0xD3 and 0 for 0xD2.
- R8: Every load of the output buffer gives a one-cycle pulse on the keyboard interrupt if the byte is keyboard-attributed and configuration bit0 is 1, or on the mouse interrupt if the byte is mouse-attributed and configuration bit1 is 1. Otherwise no pulse is given.
- R9: A data-address read returns the buffered byte and clears status bits 0 and 5 on the next cycle.
- R10: While the buffer is empty and no host load occurs, the block accepts one byte from the keyboard receive stream if it is valid; otherwise it accepts one from the mouse stream. It never accepts while the buffer is full.
- R11: Command 0x20 loads the configuration byte into the output buffer as a keyboard-attributed byte.
- R12: Commands 0xA7/0xA8 set/clear configuration bit5, and 0xAD/0xAE set/clear bit4, with no data phase.
- R13: After command 0xD1 the next data write is consumed without other effect; if its bit0 is 0 the error output is set.
- R14: Any command code not listed in R5 to R13 sets the error output, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_cmd_sel_i | input | 1 | 1 selects command/status address, 0 selects data address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte (status or buffered data) |
| kbd_tx_valid_o | output | 1 | Keyboard transmit byte valid |
| kbd_tx_data_o | output | 8 | Keyboard transmit byte |
| kbd_tx_ready_i | input | 1 | Keyboard transmit accept |
| kbd_rx_valid_i | input | 1 | Keyboard receive byte valid |
| kbd_rx_data_i | input | 8 | Keyboard receive byte |
| kbd_rx_ready_o | output | 1 | Keyboard receive accept |
| aux_tx_valid_o | output | 1 | Mouse transmit byte valid |
| aux_tx_data_o | output | 8 | Mouse transmit byte |
| aux_tx_ready_i | input | 1 | Mouse transmit accept |
| aux_rx_valid_i | input | 1 | Mouse receive byte valid |
| aux_rx_data_i | input | 8 | Mouse receive byte |
| aux_rx_ready_o | output | 1 | Mouse receive accept |
| kbd_irq_o | output | 1 | Keyboard interrupt pulse |
| aux_irq_o | output | 1 | Mouse interrupt pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
A wrong pending-action state shows up on the very next data write. The byte arrives on the wrong transmit stream, at the wrong configuration value, or as a wrong buffer load, so the per-cycle comparison catches it within one cycle. A wrong full or source flag shows at once in the status byte. It also shows in the receive-ready outputs, which are compared every cycle, and in the interrupt pulse, which appears one cycle after the load edge. Refill priority errors surface as wrong bytes in the drain order of mixed keyboard and mouse streams.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] CMD_RD_CFG    = 8'h20;
  localparam logic [7:0] CMD_WR_CFG    = 8'h60;
  localparam logic [7:0] CMD_AUX_OFF   = 8'hA7;
  localparam logic [7:0] CMD_AUX_ON    = 8'hA8;
  localparam logic [7:0] CMD_KBD_OFF   = 8'hAD;
  localparam logic [7:0] CMD_KBD_ON    = 8'hAE;
  localparam logic [7:0] CMD_WR_OPORT  = 8'hD1;
  localparam logic [7:0] CMD_LOOP_KBD  = 8'hD2;
  localparam logic [7:0] CMD_LOOP_AUX  = 8'hD3;
  localparam logic [7:0] CMD_TX_AUX    = 8'hD4;

  // status bit positions
  localparam int unsigned ST_OBF  = 0;
  localparam int unsigned ST_SYS  = 2;
  localparam int unsigned ST_CMD  = 3;
  localparam int unsigned ST_UNLK = 4;
  localparam int unsigned ST_AUXF = 5;

  // configuration bit positions
  localparam int unsigned CFG_KBD_IE  = 0;
  localparam int unsigned CFG_AUX_IE  = 1;
  localparam int unsigned CFG_SYS     = 2;
  localparam int unsigned CFG_KBD_DIS = 4;
  localparam int unsigned CFG_AUX_DIS = 5;

  localparam logic [7:0] CFG_RESET = 8'h45;

  localparam int unsigned N_CH = 2;  // 0 keyboard, 1 mouse

  typedef enum logic [2:0] {
    PEND_NONE,
    PEND_CFG,
    PEND_OPORT,
    PEND_LOOP_KBD,
    PEND_LOOP_AUX,
    PEND_TX_AUX
  } pend_e;

  typedef struct packed {
    logic       known;
    logic       arm;
    pend_e      arm_kind;
    logic       rd_cfg;
    logic       cfg_touch;
    logic [2:0] cfg_bit;
    logic       cfg_val;
  } cmd_act_t;

endpackage

// File: rtl/ps2_cmd_decode.sv
module ps2_cmd_decode
  import ps2_host_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_act_t   act_o
);

  always_comb begin
    act_o           = '0;
    act_o.known     = 1'b1;
    act_o.arm_kind  = PEND_NONE;
    case (code_i)
      CMD_RD_CFG:   act_o.rd_cfg = 1'b1;
      CMD_WR_CFG:   begin act_o.arm = 1'b1; act_o.arm_kind = PEND_CFG;      end
      CMD_WR_OPORT: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_OPORT;    end
      CMD_LOOP_KBD: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_LOOP_KBD; end
      CMD_LOOP_AUX: begin act_o.arm = 1'b1; act_o.arm_kind = PEND_LOOP_AUX; end
      CMD_TX_AUX:   begin act_o.arm = 1'b1; act_o.arm_kind = PEND_TX_AUX;   end
      CMD_AUX_OFF: begin
        act_o.cfg_touch = 1'b1; act_o.cfg_bit = 3'(CFG_AUX_DIS); act_o.cfg_val = 1'b1;
      end
      CMD_AUX_ON: begin
        act_o.cfg_touch = 1'b1; act_o.cfg_bit = 3'(CFG_AUX_DIS); act_o.cfg_val = 1'b0;
      end
      CMD_KBD_OFF: begin
        act_o.cfg_touch = 1'b1; act_o.cfg_bit = 3'(CFG_KBD_DIS); act_o.cfg_val = 1'b1;
      end
      CMD_KBD_ON: begin
        act_o.cfg_touch = 1'b1; act_o.cfg_bit = 3'(CFG_KBD_DIS); act_o.cfg_val = 1'b0;
      end
      default: act_o.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/ps2_tx_hold.sv
module ps2_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  input  logic          ready_i
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !push_i) |=> (valid_o && $stable(data_o)));

  p_push_shows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (valid_o && data_o == $past(data_i)));

endmodule

// File: rtl/ps2_out_buf.sv
module ps2_out_buf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_ld_i,
  input  logic          host_ld_aux_i,
  input  logic [DW-1:0] host_ld_data_i,
  input  logic          drain_i,
  input  logic          kbd_valid_i,
  input  logic [DW-1:0] kbd_data_i,
  output logic          kbd_ready_o,
  input  logic          aux_valid_i,
  input  logic [DW-1:0] aux_data_i,
  output logic          aux_ready_o,
  input  logic          kbd_ie_i,
  input  logic          aux_ie_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          aux_full_o,
  output logic          kbd_irq_o,
  output logic          aux_irq_o
);

  logic          refill_ok;
  logic          load;
  logic          load_aux;
  logic [DW-1:0] load_data;

  assign refill_ok   = !full_o && !host_ld_i;
  assign kbd_ready_o = refill_ok && kbd_valid_i;
  assign aux_ready_o = refill_ok && !kbd_valid_i && aux_valid_i;

  always_comb begin
    load      = host_ld_i || kbd_ready_o || aux_ready_o;
    load_aux  = host_ld_i ? host_ld_aux_i : aux_ready_o;
    load_data = host_ld_i ? host_ld_data_i : (kbd_ready_o ? kbd_data_i : aux_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o     <= '0;
      full_o     <= 1'b0;
      aux_full_o <= 1'b0;
    end else if (load) begin
      data_o     <= load_data;
      full_o     <= 1'b1;
      aux_full_o <= load_aux;
    end else if (drain_i) begin
      full_o     <= 1'b0;
      aux_full_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kbd_irq_o <= 1'b0;
      aux_irq_o <= 1'b0;
    end else begin
      kbd_irq_o <= load && !load_aux && kbd_ie_i;
      aux_irq_o <= load && load_aux && aux_ie_i;
    end
  end

  p_aux_needs_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_full_o |-> full_o);

  p_kbd_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_ready_o && aux_valid_i) |-> !kbd_valid_i);

  p_no_take_when_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !(kbd_ready_o || aux_ready_o));

  p_drain_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && full_o && !host_ld_i) |=> (!full_o && !aux_full_o));

  p_kirq_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_irq_o |-> (full_o && !aux_full_o));

  p_airq_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_irq_o |-> (full_o && aux_full_o));

endmodule

// File: rtl/ps2_host_ctrl.sv
module ps2_host_ctrl
  import ps2_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_wr_i,
  input  logic       host_rd_i,
  input  logic       host_cmd_sel_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o,
  output logic       kbd_tx_valid_o,
  output logic [7:0] kbd_tx_data_o,
  input  logic       kbd_tx_ready_i,
  input  logic       kbd_rx_valid_i,
  input  logic [7:0] kbd_rx_data_i,
  output logic       kbd_rx_ready_o,
  output logic       aux_tx_valid_o,
  output logic [7:0] aux_tx_data_o,
  input  logic       aux_tx_ready_i,
  input  logic       aux_rx_valid_i,
  input  logic [7:0] aux_rx_data_i,
  output logic       aux_rx_ready_o,
  output logic       kbd_irq_o,
  output logic       aux_irq_o,
  output logic       err_o
);

  localparam int unsigned DW = BYTE_W;

  logic          wr_cmd, wr_dat, rd_dat;
  cmd_act_t      act;
  pend_e         pend_q;
  logic [DW-1:0] cfg_q;
  logic          sys_q, cmd_last_q, err_q;

  logic          host_ld, host_ld_aux, err_set;
  logic [DW-1:0] host_ld_data;
  logic [N_CH-1:0] tx_push, tx_rdy, tx_vld;
  logic [DW-1:0] tx_dat [N_CH];

  logic [DW-1:0] ob_data;
  logic          ob_full, ob_aux;
  logic [DW-1:0] status;

  assign wr_cmd = host_wr_i && host_cmd_sel_i;
  assign wr_dat = host_wr_i && !host_cmd_sel_i;
  assign rd_dat = host_rd_i && !host_cmd_sel_i;

  ps2_cmd_decode i_dec (
    .code_i (host_wdata_i),
    .act_o  (act)
  );

  always_comb begin
    tx_push      = '0;
    host_ld      = 1'b0;
    host_ld_aux  = 1'b0;
    host_ld_data = host_wdata_i;
    err_set      = 1'b0;
    if (wr_dat) begin
      case (pend_q)
        PEND_NONE:     tx_push[0] = 1'b1;
        PEND_TX_AUX:   tx_push[1] = 1'b1;
        PEND_LOOP_KBD: host_ld = 1'b1;
        PEND_LOOP_AUX: begin host_ld = 1'b1; host_ld_aux = 1'b1; end
        PEND_OPORT:    err_set = !host_wdata_i[0];  // reset line must stay high
        default: ;
      endcase
    end
    if (wr_cmd) begin
      if (act.rd_cfg) begin
        host_ld      = 1'b1;
        host_ld_data = cfg_q;
      end
      if (!act.known) err_set = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= PEND_NONE;
      cfg_q      <= CFG_RESET;
      sys_q      <= 1'b1;
      cmd_last_q <= 1'b1;
      err_q      <= 1'b0;
    end else begin
      if (wr_dat) begin
        cmd_last_q <= 1'b0;
        pend_q     <= PEND_NONE;
        if (pend_q == PEND_CFG) begin
          cfg_q <= host_wdata_i;
          sys_q <= host_wdata_i[CFG_SYS];
        end
      end
      if (wr_cmd) begin
        cmd_last_q <= 1'b1;
        if (act.arm) pend_q <= act.arm_kind;
        if (act.cfg_touch) cfg_q[act.cfg_bit] <= act.cfg_val;
      end
      if (err_set) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_tx
    ps2_tx_hold #(.DW(DW)) i_tx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (tx_push[ch]),
      .data_i  (host_wdata_i),
      .valid_o (tx_vld[ch]),
      .data_o  (tx_dat[ch]),
      .ready_i (tx_rdy[ch])
    );
  end

  assign tx_rdy         = {aux_tx_ready_i, kbd_tx_ready_i};
  assign kbd_tx_valid_o = tx_vld[0];
  assign kbd_tx_data_o  = tx_dat[0];
  assign aux_tx_valid_o = tx_vld[1];
  assign aux_tx_data_o  = tx_dat[1];

  ps2_out_buf #(.DW(DW)) i_obuf (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .host_ld_i      (host_ld),
    .host_ld_aux_i  (host_ld_aux),
    .host_ld_data_i (host_ld_data),
    .drain_i        (rd_dat),
    .kbd_valid_i    (kbd_rx_valid_i),
    .kbd_data_i     (kbd_rx_data_i),
    .kbd_ready_o    (kbd_rx_ready_o),
    .aux_valid_i    (aux_rx_valid_i),
    .aux_data_i     (aux_rx_data_i),
    .aux_ready_o    (aux_rx_ready_o),
    .kbd_ie_i       (cfg_q[CFG_KBD_IE]),
    .aux_ie_i       (cfg_q[CFG_AUX_IE]),
    .data_o         (ob_data),
    .full_o         (ob_full),
    .aux_full_o     (ob_aux),
    .kbd_irq_o      (kbd_irq_o),
    .aux_irq_o      (aux_irq_o)
  );

  always_comb begin
    status          = '0;
    status[ST_OBF]  = ob_full;
    status[ST_SYS]  = sys_q;
    status[ST_CMD]  = cmd_last_q;
    status[ST_UNLK] = 1'b1;
    status[ST_AUXF] = ob_aux;
  end

  assign host_rdata_o = host_cmd_sel_i ? status : ob_data;

  p_cmd_last_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> host_rdata_o[ST_CMD] || !host_cmd_sel_i);

  p_cmd_last_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dat |=> !cmd_last_q);

  p_pend_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dat |=> pend_q == PEND_NONE);

  p_cfg_sys_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && pend_q == PEND_CFG) |=> sys_q == $past(host_wdata_i[CFG_SYS]));

  p_unknown_err_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !act.known) |=> err_o);

  p_err_sticky_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_loop_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && pend_q == PEND_LOOP_AUX) |=> (ob_full && ob_aux));

endmodule

// File: tb/test_ps2_host_ctrl.sv
`timescale 1ns/1ps
module test_ps2_host_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       wr = 0, rd = 0, sel = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic       ktv, atv, ktr = 0, atr = 0;
  logic [7:0] ktd, atd;
  logic       krv = 0, arv = 0, krr, arr;
  logic [7:0] krd = 0, ard = 0;
  logic       kirq, airq, err;

  ps2_host_ctrl i_ps2_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(wr), .host_rd_i(rd), .host_cmd_sel_i(sel),
    .host_wdata_i(wd), .host_rdata_o(rdata),
    .kbd_tx_valid_o(ktv), .kbd_tx_data_o(ktd), .kbd_tx_ready_i(ktr),
    .kbd_rx_valid_i(krv), .kbd_rx_data_i(krd), .kbd_rx_ready_o(krr),
    .aux_tx_valid_o(atv), .aux_tx_data_o(atd), .aux_tx_ready_i(atr),
    .aux_rx_valid_i(arv), .aux_rx_data_i(ard), .aux_rx_ready_o(arr),
    .kbd_irq_o(kirq), .aux_irq_o(airq), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] kq[$];
  logic [7:0] aq[$];
  logic [7:0] m_data, m_cfg, m_ktd, m_atd;
  logic m_full, m_auxf, m_sys, m_cmdlast, m_err, m_kirq, m_airq, m_ktv, m_atv;
  int m_pend;  // 0 none 1 cfg 2 oport 3 loop kbd 4 loop aux 5 tx aux

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {2'b00, m_auxf, 1'b1, m_cmdlast, m_sys, 1'b0, m_full};
  endfunction

  function automatic void present();
    krv = (kq.size() != 0);
    krd = krv ? kq[0] : 8'h00;
    arv = (aq.size() != 0);
    ard = arv ? aq[0] : 8'h00;
  endfunction

  function automatic void model_reset();
    m_data = 0; m_full = 0; m_auxf = 0; m_cfg = 8'h45; m_sys = 1; m_cmdlast = 1;
    m_err = 0; m_kirq = 0; m_airq = 0; m_ktv = 0; m_atv = 0; m_ktd = 0; m_atd = 0;
    m_pend = 0;
  endfunction

  function automatic logic host_load_now();
    return (wr && !sel && (m_pend == 3 || m_pend == 4)) || (wr && sel && wd == 8'h20);
  endfunction

  function automatic void model_tick();
    logic hl, hla, kp, ap, kr, ar, ld, lda;
    logic [7:0] hld, ldd, cfg0;
    cfg0 = m_cfg; hl = 0; hla = 0; hld = wd; kp = 0; ap = 0;
    if (wr && !sel) begin
      case (m_pend)
        0: kp = 1;
        5: ap = 1;
        1: begin m_cfg = wd; m_sys = wd[2]; end
        3: hl = 1;
        4: begin hl = 1; hla = 1; end
        2: if (!wd[0]) m_err = 1;
        default: ;
      endcase
      m_pend = 0; m_cmdlast = 0;
    end
    if (wr && sel) begin
      m_cmdlast = 1;
      case (wd)
        8'h20: begin hl = 1; hld = cfg0; end
        8'h60: m_pend = 1;
        8'hD1: m_pend = 2;
        8'hD2: m_pend = 3;
        8'hD3: m_pend = 4;
        8'hD4: m_pend = 5;
        8'hA7: m_cfg[5] = 1;
        8'hA8: m_cfg[5] = 0;
        8'hAD: m_cfg[4] = 1;
        8'hAE: m_cfg[4] = 0;
        default: m_err = 1;
      endcase
    end
    kr = !m_full && !hl && kq.size() != 0;
    ar = !m_full && !hl && kq.size() == 0 && aq.size() != 0;
    ld = hl || kr || ar;
    lda = hl ? hla : ar;
    ldd = hl ? hld : (kr ? kq[0] : (ar ? aq[0] : 8'h00));
    m_kirq = ld && !lda && cfg0[0];
    m_airq = ld && lda && cfg0[1];
    if (ld) begin m_data = ldd; m_full = 1; m_auxf = lda; end
    else if (rd && !sel) begin m_full = 0; m_auxf = 0; end
    if (kp) begin m_ktv = 1; m_ktd = wd; end else if (m_ktv && ktr) m_ktv = 0;
    if (ap) begin m_atv = 1; m_atd = wd; end else if (m_atv && atr) m_atv = 0;
    if (kr) void'(kq.pop_front());
    if (ar) void'(aq.pop_front());
    present();
  endfunction

  task automatic compare_all();
    logic hl;
    hl = host_load_now();
    chk(sel ? "R2 rdata" : "R9 rdata", rdata, sel ? m_status() : m_data);
    chk("R4 kbd_tx_valid", ktv, m_ktv);
    if (m_ktv) chk("R4 kbd_tx_data", ktd, m_ktd);
    chk("R5 aux_tx_valid", atv, m_atv);
    if (m_atv) chk("R5 aux_tx_data", atd, m_atd);
    chk("R10 kbd_rx_ready", krr, !m_full && !hl && kq.size() != 0);
    chk("R10 aux_rx_ready", arr, !m_full && !hl && kq.size() == 0 && aq.size() != 0);
    chk("R8 kbd_irq", kirq, m_kirq);
    chk("R8 aux_irq", airq, m_airq);
    chk("R14 err", err, m_err);
  endtask

  task automatic step();
    @(posedge clk); #1;
    if (rst_n) model_tick();
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic do_reset();
    rst_n = 0; wr = 0; rd = 0; sel = 0;
    kq.delete(); aq.delete(); present();
    repeat (2) @(negedge clk);
    rst_n = 1; model_reset();
  endtask

  task automatic cmd(input logic [7:0] b);
    sel = 1; wr = 1; wd = b; step(); wr = 0;
  endtask

  task automatic dat(input logic [7:0] b);
    sel = 0; wr = 1; wd = b; step(); wr = 0;
  endtask

  task automatic hrd(input logic s, output logic [7:0] v);
    sel = s; rd = 1; #1 v = rdata; step(); rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    logic [7:0] v;
    present();
    do_reset();
    idle(1);
    // R1 reset state
    hrd(1, v); chk("R1 status reset", v, 8'h1C);
    chk("R1 err reset", err, 0);
    cmd(8'h20);
    chk("R11 kbd irq on cfg read", kirq, 1);
    hrd(1, v); chk("R2 status full", v, 8'h1D);
    hrd(1, v); chk("R2 status read no side effect", v, 8'h1D);
    hrd(0, v); chk("R1 config reset", v, 8'h45);
    hrd(1, v); chk("R9 full cleared", v, 8'h1C);
    // R4 keyboard transmit hold
    ktr = 0; dat(8'hF4);
    idle(3);
    chk("R4 hold valid", ktv, 1); chk("R4 hold data", ktd, 8'hF4);
    hrd(1, v); chk("R3 cmd_last cleared", v, 8'h14);
    ktr = 1; idle(2); chk("R4 accepted", ktv, 0);
    // R5 mouse transmit then back to keyboard
    atr = 0; cmd(8'hD4); dat(8'h55);
    chk("R5 aux tx", atv, 1); chk("R5 aux data", atd, 8'h55);
    chk("R5 kbd untouched", ktv, 0);
    atr = 1; dat(8'h66);
    chk("R5 pending cleared", ktv, 1); chk("R5 kbd data", ktd, 8'h66);
    idle(2);
    // R6 config write
    cmd(8'h60); dat(8'h03);
    hrd(1, v); chk("R6 sys copied", v, 8'h10);
    cmd(8'h20); hrd(0, v); chk("R6 config value", v, 8'h03);
    // R7 loopbacks
    cmd(8'hD3); dat(8'hA5);
    chk("R8 aux irq pulse", airq, 1);
    hrd(1, v); chk("R7 aux loop status", v, 8'h31);
    chk("R8 aux irq one cycle", airq, 0);
    hrd(0, v); chk("R9 aux loop byte", v, 8'hA5);
    cmd(8'hD2); dat(8'h5A);
    chk("R8 kbd irq pulse", kirq, 1);
    hrd(1, v); chk("R7 kbd loop status", v, 8'h11);
    hrd(0, v); chk("R9 kbd loop byte", v, 8'h5A);
    // R10 refill priority
    cmd(8'hD2); dat(8'h11);
    kq.push_back(8'h1C); kq.push_back(8'h2D); aq.push_back(8'h77); present();
    idle(2);
    hrd(0, v); chk("R10 held byte", v, 8'h11);
    idle(1); hrd(0, v); chk("R10 kbd first", v, 8'h1C);
    idle(1); hrd(0, v); chk("R10 kbd second", v, 8'h2D);
    idle(1); hrd(1, v); chk("R10 aux status", v, 8'h31);
    hrd(0, v); chk("R10 aux last", v, 8'h77);
    idle(2);
    // R12 enable/disable bits
    cmd(8'hA7); cmd(8'hAD); cmd(8'h20); hrd(0, v); chk("R12 disables", v, 8'h33);
    cmd(8'hA8); cmd(8'hAE); cmd(8'h20); hrd(0, v); chk("R12 enables", v, 8'h03);
    // R8 interrupts masked
    cmd(8'h60); dat(8'h04);
    cmd(8'hD2); dat(8'h42); chk("R8 kbd irq masked", kirq, 0);
    hrd(0, v);
    cmd(8'hD3); dat(8'h43); chk("R8 aux irq masked", airq, 0);
    hrd(0, v);
    // R13 output port
    cmd(8'hD1); dat(8'h01); idle(1); chk("R13 bit0 high no err", err, 0);
    hrd(1, v); chk("R13 no other effect", v, 8'h14);
    cmd(8'hD1); dat(8'h00); chk("R13 bit0 low err", err, 1);
    // R14 unknown command
    do_reset(); idle(1);
    cmd(8'hAA); chk("R14 unknown sets err", err, 1);
    idle(3); chk("R14 err sticky", err, 1);
    cmd(8'h20); hrd(0, v); chk("R14 config intact", v, 8'h45);
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule